// File: doc/BRIEF.md
# Control-Flow Next-PC Resolver

This block resolves where a small core's program counter goes after a control-flow instruction, and how many cycles that instruction costs. It handles relative and pointer-based jumps and calls, subroutine and interrupt returns, conditional branches on any status flag, and skips. A skip can be driven by a compare-equal result or by the value of one tested register or I/O bit. For each instruction the block reports the following:

- the next PC;
- whether control flow was redirected;
- the total cycle count;
- whether a return address must be pushed, and which one;
- whether the global interrupt enable must be set.

Requests arrive on a valid/ready input channel, one instruction per beat. Results leave on a valid/ready output channel through a single register stage. A request is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken. The stack memory and instruction fetch belong to the core around this block.

Top module: `bsu_next_pc`

## Requirements
- R1: Class 0 (relative jump) and class 2 (relative call) give next PC = PC + sign-extended 12-bit `rel_ofs` + 1, modulo 2^PC_W.
- R2: Class 1 (pointer jump) and class 3 (pointer call) give next PC = `z_ptr`.
- R3: Jumps (classes 0, 1) report 2 cycles, calls (classes 2, 3) report 3 cycles, and returns (classes 4, 5) report 4 cycles. All six report `taken` = 1.
- R4: Calls assert `push_en` with `push_addr` = PC + 1. No other class asserts `push_en`.
- R5: Class 4 (subroutine return) and class 5 (interrupt return) give next PC = `ret_addr`. Only class 5 asserts `set_ie`.
- R6: Class 6 (conditional branch) tests status bit `cond_sel[2:0]` of `sreg`. The bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. The branch is taken when that bit equals `cond_sel[3]`.
- R7: For index 4 (signed compare), the tested value is `sreg[2]` XOR `sreg[3]`; the stored `sreg[4]` has no effect.
- R8: A taken branch gives PC + sign-extended `rel_ofs[6:0]` + 1 and 2 cycles. A branch that is not taken gives PC + 1 and 1 cycle, with `taken` = 0. `rel_ofs[11:7]` has no effect on branches.
- R9: Skip classes have these conditions: class 7 holds when `cmp_eq` = 1, class 8 when `test_bit` = 0, and class 9 when `test_bit` = 1. When the condition holds, the result is PC + 2 and 2 cycles, or PC + 3 and 3 cycles when `next_two_word` = 1, with `taken` = 1. Otherwise the result is PC + 1 and 1 cycle, with `taken` = 0.
- R10: Classes 10 to 15 give PC + 1, 1 cycle, `taken` = 0, and no push or `set_ie`.
- R11: A result appears on the output one clock after its request is accepted. `in_ready` is high exactly when the output register is empty or `out_ready` is high. A stalled result stays stable.
- R12: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| cf_class | input | 4 | Instruction class (0 to 9 defined) |
| cond_sel | input | 4 | Branch flag index [2:0] and sense [3] |
| pc | input | PC_W | Address of the current instruction |
| rel_ofs | input | 12 | Signed relative offset (low 7 bits for branches) |
| z_ptr | input | PC_W | Pointer target for indirect jump or call |
| ret_addr | input | PC_W | Address popped for returns |
| sreg | input | 8 | Status flags |
| test_bit | input | 1 | Value of the tested register or I/O bit |
| cmp_eq | input | 1 | Compare-equal indication for class 7 |
| next_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| next_pc | output | PC_W | Resolved next PC |
| taken | output | 1 | Control flow redirected or skip performed |
| cycles | output | 3 | Cycle count of the instruction |
| push_en | output | 1 | Return address must be pushed |
| push_addr | output | PC_W | Return address to push |
| set_ie | output | 1 | Set global interrupt enable |

## Verification
Every result is due exactly one clock after the edge that accepts its request. The bench therefore drives a request at a falling edge and drops `in_valid` at the next falling edge. At that same falling edge, after one rising edge, it samples all outputs.

For back-pressure, the bench holds `out_ready` low for several cycles. It confirms that `in_ready` stays low and the held result does not change. It then raises `out_ready` and expects the waiting request's result one edge later. The branch sweep covers every condition select against all 256 status patterns, and the expected values are computed arithmetically from the requirement rules.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [3:0] {
    CF_RJMP   = 4'd0,
    CF_IJMP   = 4'd1,
    CF_RCALL  = 4'd2,
    CF_ICALL  = 4'd3,
    CF_RET    = 4'd4,
    CF_RETI   = 4'd5,
    CF_BRCOND = 4'd6,
    CF_SKEQ   = 4'd7,
    CF_SKBC   = 4'd8,
    CF_SKBS   = 4'd9
  } cf_class_e;

  localparam int CYC_W     = 3;
  localparam int SREG_W    = 8;
  localparam int FLAG_N    = 2;
  localparam int FLAG_V    = 3;
  localparam int FLAG_SIGN = 4;

  localparam logic [CYC_W-1:0] CYC_ONE   = 3'd1;
  localparam logic [CYC_W-1:0] CYC_JUMP  = 3'd2;
  localparam logic [CYC_W-1:0] CYC_CALL  = 3'd3;
  localparam logic [CYC_W-1:0] CYC_RET   = 3'd4;
  localparam logic [CYC_W-1:0] CYC_BRT   = 3'd2;
  localparam logic [CYC_W-1:0] CYC_SK1   = 3'd2;
  localparam logic [CYC_W-1:0] CYC_SK2   = 3'd3;
endpackage

// File: rtl/bsu_pc_adder.sv
module bsu_pc_adder #(
  parameter int PC_W  = 16,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]  base,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  target
);
  localparam logic [PC_W-1:0] INC = PC_W'(1);
  logic [PC_W-1:0] ofs_ext;

  generate
    if (PC_W > OFS_W) begin : g_extend
      assign ofs_ext = {{(PC_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    end else begin : g_trunc
      assign ofs_ext = ofs[PC_W-1:0];
    end
  endgenerate

  assign target = base + ofs_ext + INC;
endmodule

// File: rtl/bsu_cond_eval.sv
module bsu_cond_eval
  import bsu_pkg::*;
#(
  parameter int SEL_W = $clog2(SREG_W)
) (
  input  cf_class_e         cls,
  input  logic [SEL_W:0]    cond_sel,
  input  logic [SREG_W-1:0] sreg,
  input  logic              test_bit,
  input  logic              cmp_eq,
  output logic              br_take,
  output logic              skip_hold
);
  logic [SREG_W-1:0] eff_flags;
  logic              unused_stored_sign;

  assign unused_stored_sign = sreg[FLAG_SIGN];

  generate
    for (genvar i = 0; i < SREG_W; i++) begin : g_flag
      if (i == FLAG_SIGN) begin : g_sign
        assign eff_flags[i] = sreg[FLAG_N] ^ sreg[FLAG_V];
      end else begin : g_plain
        assign eff_flags[i] = sreg[i];
      end
    end
  endgenerate

  logic picked;
  assign picked  = eff_flags[cond_sel[SEL_W-1:0]];
  assign br_take = (picked == cond_sel[SEL_W]);

  always_comb begin
    case (cls)
      CF_SKEQ: skip_hold = cmp_eq;
      CF_SKBC: skip_hold = ~test_bit;
      CF_SKBS: skip_hold = test_bit;
      default: skip_hold = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsu_resolve.sv
module bsu_resolve
  import bsu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  cf_class_e         cls,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   rel_tgt,
  input  logic [PC_W-1:0]   br_tgt,
  input  logic [PC_W-1:0]   z_ptr,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic              br_take,
  input  logic              skip_hold,
  input  logic              next_two_word,
  output logic [PC_W-1:0]   nxt,
  output logic [PC_W-1:0]   ret_push,
  output logic              tk,
  output logic [CYC_W-1:0]  cyc,
  output logic              psh,
  output logic              sie
);
  logic [PC_W-1:0] pc_p1, pc_p2, pc_p3;
  assign pc_p1    = pc + PC_W'(1);
  assign pc_p2    = pc + PC_W'(2);
  assign pc_p3    = pc + PC_W'(3);
  assign ret_push = pc_p1;

  always_comb begin
    nxt = pc_p1;
    tk  = 1'b0;
    cyc = CYC_ONE;
    psh = 1'b0;
    sie = 1'b0;
    case (cls)
      CF_RJMP:  begin nxt = rel_tgt;  tk = 1'b1; cyc = CYC_JUMP; end
      CF_IJMP:  begin nxt = z_ptr;    tk = 1'b1; cyc = CYC_JUMP; end
      CF_RCALL: begin nxt = rel_tgt;  tk = 1'b1; cyc = CYC_CALL; psh = 1'b1; end
      CF_ICALL: begin nxt = z_ptr;    tk = 1'b1; cyc = CYC_CALL; psh = 1'b1; end
      CF_RET:   begin nxt = ret_addr; tk = 1'b1; cyc = CYC_RET; end
      CF_RETI:  begin nxt = ret_addr; tk = 1'b1; cyc = CYC_RET; sie = 1'b1; end
      CF_BRCOND: begin
        if (br_take) begin
          nxt = br_tgt;
          tk  = 1'b1;
          cyc = CYC_BRT;
        end
      end
      CF_SKEQ, CF_SKBC, CF_SKBS: begin
        if (skip_hold) begin
          tk  = 1'b1;
          nxt = next_two_word ? pc_p3 : pc_p2;
          cyc = next_two_word ? CYC_SK2 : CYC_SK1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsu_next_pc.sv
module bsu_next_pc
  import bsu_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int JMP_OFS_W = 12,
  parameter int BR_OFS_W  = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0]           cf_class,
  input  logic [3:0]           cond_sel,
  input  logic [PC_W-1:0]      pc,
  input  logic [JMP_OFS_W-1:0] rel_ofs,
  input  logic [PC_W-1:0]      z_ptr,
  input  logic [PC_W-1:0]      ret_addr,
  input  logic [SREG_W-1:0]    sreg,
  input  logic                 test_bit,
  input  logic                 cmp_eq,
  input  logic                 next_two_word,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PC_W-1:0]      next_pc,
  output logic                 taken,
  output logic [CYC_W-1:0]     cycles,
  output logic                 push_en,
  output logic [PC_W-1:0]      push_addr,
  output logic                 set_ie
);
  cf_class_e       cls;
  logic [PC_W-1:0] rel_tgt, br_tgt, nxt, ret_push;
  logic            br_take, skip_hold, tk, psh, sie;
  logic [CYC_W-1:0] cyc;
  logic            accept;

  assign cls = cf_class_e'(cf_class);

  bsu_pc_adder #(.PC_W(PC_W), .OFS_W(JMP_OFS_W)) u_rel_add (
    .base(pc), .ofs(rel_ofs), .target(rel_tgt)
  );

  bsu_pc_adder #(.PC_W(PC_W), .OFS_W(BR_OFS_W)) u_br_add (
    .base(pc), .ofs(rel_ofs[BR_OFS_W-1:0]), .target(br_tgt)
  );

  bsu_cond_eval u_cond (
    .cls(cls), .cond_sel(cond_sel), .sreg(sreg), .test_bit(test_bit),
    .cmp_eq(cmp_eq), .br_take(br_take), .skip_hold(skip_hold)
  );

  bsu_resolve #(.PC_W(PC_W)) u_res (
    .cls(cls), .pc(pc), .rel_tgt(rel_tgt), .br_tgt(br_tgt), .z_ptr(z_ptr),
    .ret_addr(ret_addr), .br_take(br_take), .skip_hold(skip_hold),
    .next_two_word(next_two_word), .nxt(nxt), .ret_push(ret_push),
    .tk(tk), .cyc(cyc), .psh(psh), .sie(sie)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      cycles    <= '0;
      push_en   <= 1'b0;
      push_addr <= '0;
      set_ie    <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        next_pc   <= nxt;
        taken     <= tk;
        cycles    <= cyc;
        push_en   <= psh;
        push_addr <= ret_push;
        set_ie    <= sie;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsu_next_pc_chk.sv
module bsu_next_pc_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic [2:0]      cycles,
  input logic            push_en,
  input logic            set_ie
);
  p_reset_idle_r12: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_to_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(next_pc) && $stable(cycles)
      && $stable(taken) && $stable(push_en) && $stable(set_ie));

  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_call_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && push_en |-> cycles == 3'd3 && taken && !set_ie);

  p_reti_cost_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && set_ie |-> cycles == 3'd4 && taken && !push_en);

  p_fallthrough_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !taken |-> cycles == 3'd1);

  p_cycle_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cycles >= 3'd1 && cycles <= 3'd4);
endmodule

bind bsu_next_pc bsu_next_pc_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .next_pc(next_pc),
  .taken(taken), .cycles(cycles), .push_en(push_en), .set_ie(set_ie)
);

// File: tb/tb_bsu_next_pc.sv
module tb_bsu_next_pc;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [3:0] cf_class = '0, cond_sel = '0;
  logic [PC_W-1:0] pc = '0, z_ptr = '0, ret_addr = '0;
  logic [11:0] rel_ofs = '0;
  logic [7:0] sreg = '0;
  logic test_bit = 1'b0, cmp_eq = 1'b0, next_two_word = 1'b0;
  logic [PC_W-1:0] next_pc, push_addr;
  logic taken, push_en, set_ie;
  logic [2:0] cycles;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [PC_W-1:0] e_pc, e_push_addr;
  logic e_tk, e_push, e_sie;
  logic [2:0] e_cyc;

  always #10 clk = ~clk;

  bsu_next_pc #(.PC_W(PC_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cf_class(cf_class), .cond_sel(cond_sel), .pc(pc), .rel_ofs(rel_ofs),
    .z_ptr(z_ptr), .ret_addr(ret_addr), .sreg(sreg), .test_bit(test_bit),
    .cmp_eq(cmp_eq), .next_two_word(next_two_word), .out_valid(out_valid),
    .out_ready(out_ready), .next_pc(next_pc), .taken(taken), .cycles(cycles),
    .push_en(push_en), .push_addr(push_addr), .set_ie(set_ie)
  );

  task automatic model();
    logic flag;
    logic hold;
    e_pc = pc + 16'd1; e_tk = 1'b0; e_cyc = 3'd1; e_push = 1'b0; e_sie = 1'b0;
    e_push_addr = pc + 16'd1;
    case (cf_class)
      4'd0, 4'd2: begin
        e_pc = pc + 16'($signed(rel_ofs)) + 16'd1; e_tk = 1'b1;
        e_cyc = (cf_class == 4'd0) ? 3'd2 : 3'd3; e_push = (cf_class == 4'd2);
      end
      4'd1, 4'd3: begin
        e_pc = z_ptr; e_tk = 1'b1;
        e_cyc = (cf_class == 4'd1) ? 3'd2 : 3'd3; e_push = (cf_class == 4'd3);
      end
      4'd4, 4'd5: begin
        e_pc = ret_addr; e_tk = 1'b1; e_cyc = 3'd4; e_sie = (cf_class == 4'd5);
      end
      4'd6: begin
        flag = (cond_sel[2:0] == 3'd4) ? (sreg[2] ^ sreg[3]) : sreg[cond_sel[2:0]];
        if (flag == cond_sel[3]) begin
          e_pc = pc + 16'($signed(rel_ofs[6:0])) + 16'd1; e_tk = 1'b1; e_cyc = 3'd2;
        end
      end
      4'd7, 4'd8, 4'd9: begin
        hold = (cf_class == 4'd7) ? cmp_eq : (cf_class == 4'd8) ? !test_bit : test_bit;
        if (hold) begin
          e_tk = 1'b1;
          e_pc = pc + (next_two_word ? 16'd3 : 16'd2);
          e_cyc = next_two_word ? 3'd3 : 3'd2;
        end
      end
      default: ;
    endcase
  endtask

  task automatic check_out(input string req);
    bit bad;
    checks++;
    bad = !out_valid || next_pc !== e_pc || taken !== e_tk || cycles !== e_cyc ||
          push_en !== e_push || set_ie !== e_sie || (e_push && push_addr !== e_push_addr);
    if (bad) begin
      failures++;
      $display("FAIL %s class=%0d got v=%b pc=%h tk=%b cyc=%0d push=%b/%h ie=%b exp pc=%h tk=%b cyc=%0d push=%b/%h ie=%b",
               req, cf_class, out_valid, next_pc, taken, cycles, push_en, push_addr, set_ie,
               e_pc, e_tk, e_cyc, e_push, e_push_addr, e_sie);
    end
  endtask

  task automatic send(input string req);
    in_valid = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R12 reset state got v=%b rdy=%b exp v=0 rdy=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4: relative jump and call, with offsets including wrap
    for (int c = 0; c < 4; c += 2) begin
      for (int i = 0; i < 8; i++) begin
        cf_class = 4'(c);
        pc = 16'(i * 16'h2345 + 16'hFFF0);
        rel_ofs = 12'(i * 12'h3A7 + 12'h801);
        send(c == 0 ? "R1 rel jump" : "R4 rel call");
      end
    end
    // R2 R3: pointer jump and call
    for (int c = 1; c < 4; c += 2) begin
      for (int i = 0; i < 4; i++) begin
        cf_class = 4'(c); pc = 16'(i * 16'h1111); z_ptr = 16'(16'hBEEF ^ (i << 4));
        send("R2 pointer target");
      end
    end
    // R5: returns
    for (int c = 4; c < 6; c++) begin
      cf_class = 4'(c); pc = 16'h1234; ret_addr = 16'(16'hA5A0 + c);
      send("R5 return");
    end
    // R6 R7 R8: all condition selects against all status patterns
    cf_class = 4'd6; pc = 16'h8000;
    for (int s = 0; s < 256; s++) begin
      for (int cs = 0; cs < 16; cs++) begin
        sreg = 8'(s); cond_sel = 4'(cs);
        rel_ofs = {5'(s), 7'((s * 13 + cs) & 8'h7F)};
        send("R6 R7 R8 branch");
      end
    end
    // R9: skips over every condition input combination
    for (int c = 7; c < 10; c++) begin
      for (int k = 0; k < 8; k++) begin
        cf_class = 4'(c); cmp_eq = k[0]; test_bit = k[1]; next_two_word = k[2];
        pc = 16'hFFFE;
        send("R9 skip");
      end
    end
    // R10: undefined classes
    for (int c = 10; c < 16; c++) begin
      cf_class = 4'(c); pc = 16'(c * 16'h0101); cmp_eq = 1'b1; test_bit = 1'b1;
      send("R10 undefined class");
    end

    // R11: back-pressure
    out_ready = 1'b0;
    cf_class = 4'd1; z_ptr = 16'h4242; pc = 16'h0010;
    in_valid = 1'b1; model();
    @(negedge clk);
    check_out("R11 first result");
    cf_class = 4'd4; ret_addr = 16'h7777;
    repeat (3) @(negedge clk);
    checks++;
    if (in_ready !== 1'b0 || next_pc !== 16'h4242 || cycles !== 3'd2) begin
      failures++;
      $display("FAIL R11 stall hold got rdy=%b pc=%h cyc=%0d exp rdy=0 pc=4242 cyc=2",
               in_ready, next_pc, cycles);
    end
    out_ready = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    check_out("R11 queued result after release");
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 drain got v=%b exp v=0", out_valid);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule